// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Sequencer

This block gets the operand of a read-type instruction for an 8-bit processor core with a 16-bit address bus. The opcode byte has already been fetched, and the program counter points at the first operand byte. The core pulses `start_i` with a mode code and the current X and Y index values. The sequencer then drives one memory address per cycle and asks the external program counter to advance past each operand byte it consumes. It ends with a one-cycle `done_o` pulse that carries the operand byte.

Every addressing mode has its own fixed sequence of bus cycles. Zero-page indexing and zero-page pointer fetches wrap within page 0. Absolute-indexed and indirect-indexed modes add the index to the low address byte only. They spend an extra cycle fixing up the high byte, but only when that addition carries.

Memory is a single-cycle read port: the byte addressed by `mem_addr_o` is on `mem_rdata_i` in the same cycle and is captured at the next clock edge. The external program counter increments at each clock edge where `pc_inc_o` is high.

Top module: `operand_fetch_seq`

## Requirements
- R1: While reset is applied and after its release with no start, `busy_o`, `done_o` and `pc_inc_o` are low.
- R2: In the first busy cycle of every mode, the address is `pc_i` and `pc_inc_o` is high. For immediate mode (code 0), the byte read there is the operand, the operation takes 1 busy cycle and 1 PC increment.
- R3: Zero page (code 1) reads the operand at {0x00, low byte}, in 2 busy cycles with 1 PC increment.
- R4: Zero page X (code 2) and zero page Y (code 3) read at {0x00, (low + index) mod 256}, in 3 busy cycles with 1 PC increment.
- R5: Absolute (code 4) reads the high byte at the next PC location and the operand at {high, low}, in 3 busy cycles with 2 PC increments.
- R6: Absolute X (code 5) and absolute Y (code 6) read the operand at the 16-bit sum {high, low} + index, with 2 PC increments. They take 3 busy cycles when low + index ≤ 255 and 4 when it exceeds 255.
- R7: Indexed-indirect (code 7) forms pointer P = (low + X) mod 256. It reads the address low byte at {0x00, P} and the high byte at {0x00, (P + 1) mod 256}, then reads the operand there. This takes 5 busy cycles with 1 PC increment.
- R8: Indirect-indexed (code 8) reads a base from {0x00, low} and {0x00, (low + 1) mod 256}, then reads the operand at base + Y. This takes 4 busy cycles, or 5 when the low base byte + Y exceeds 255, with 1 PC increment.
- R9: `done_o` is high for exactly one cycle, the cycle after the last busy cycle, with `busy_o` low and `operand_o` holding the operand.
- R10: A start pulse while `busy_o` is high is ignored: the running operation keeps its mode, cycle count and result.
- R11: A start with a mode code of 9 to 15 is ignored: `busy_o` stays low and `pc_inc_o` stays low.
- R12: The X and Y values are sampled at the accepted start. Later changes on `x_i`/`y_i` do not alter the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operand fetch (taken only when idle) |
| mode_i | input | 4 | Addressing mode code 0..8 |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y index value |
| pc_i | input | 16 | Current program counter |
| pc_inc_o | output | 1 | Request PC increment at this clock edge |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data for `mem_addr_o`, same cycle |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| operand_o | output | 8 | Operand byte, valid with `done_o` |

## Verification
The bench builds the block with its default byte width of 8, which gives a 16-bit address. At that width, page 0 is 256 bytes and the low-byte carry can be driven to both sides of the 255 boundary, so the wrap and crossing cases can be set up directly. The cases covered are pointers sitting at 0xFF, an index sum of exactly 255, and a zero-page index running past 0xFF. Random mode, index and operand bytes are laid over a computed memory image, and the bench compares operand, busy-cycle count and PC advance against its own model.

// File: rtl/ofs_pkg.sv
// Package: shared constants and types for the operand fetch sequencer.
// Assumes byte-wide data and a two-byte address.
package ofs_pkg;

    localparam int MODE_W    = 4;
    localparam int MODE_LAST = 8;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM  = 4'd0,
        AM_ZP   = 4'd1,
        AM_ZPX  = 4'd2,
        AM_ZPY  = 4'd3,
        AM_ABS  = 4'd4,
        AM_ABSX = 4'd5,
        AM_ABSY = 4'd6,
        AM_INDX = 4'd7,
        AM_INDY = 4'd8
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_C0   = 3'd1,
        ST_C1   = 3'd2,
        ST_C2   = 3'd3,
        ST_C3   = 3'd4,
        ST_C4   = 3'd5
    } step_e;

endpackage

// File: rtl/ofs_index_add.sv
// Module: adds an index to an address low byte and reports the carry
// out of that byte. Assumes unsigned operands of equal width.
module ofs_index_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] index_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    // Purpose: one W-bit add with carry out.
    always_comb begin
        {carry_o, sum_o} = {1'b0, base_i} + {1'b0, index_i};
    end

endmodule

// File: rtl/ofs_step_decode.sv
// Module: per-step, per-mode decode of the bus cycle. From the current
// step, mode and working bytes it produces the address, the PC increment
// request, the next values of the working bytes, the next step and
// whether this cycle's read is the operand. Purely combinational.
// Assumes the read data for the produced address arrives in the same cycle.
module ofs_step_decode
    import ofs_pkg::*;
#(
    parameter int W = 8
) (
    input  step_e              step_i,
    input  amode_e             mode_i,
    input  logic [W-1:0]       lo_i,
    input  logic [W-1:0]       hi_i,
    input  logic [W-1:0]       ptr_i,
    input  logic [W-1:0]       x_i,
    input  logic [W-1:0]       y_i,
    input  logic [2*W-1:0]     pc_i,
    input  logic [W-1:0]       rdata_i,
    output logic [2*W-1:0]     addr_o,
    output logic               pc_inc_o,
    output logic               last_o,
    output step_e              step_nx_o,
    output logic [W-1:0]       lo_nx_o,
    output logic [W-1:0]       hi_nx_o,
    output logic [W-1:0]       ptr_nx_o
);

    localparam logic [W-1:0] ZERO_PAGE = '0;
    localparam logic [W-1:0] ONE       = W'(1);

    logic         use_x;
    logic [W-1:0] idx;
    logic [W-1:0] sum;
    logic         carry;
    logic [W-1:0] hi_p1;
    logic [W-1:0] ptr_p1;

    // Purpose: choose which index register the mode adds.
    always_comb begin
        use_x = (mode_i == AM_ZPX) || (mode_i == AM_ABSX) || (mode_i == AM_INDX);
        idx   = use_x ? x_i : y_i;
        hi_p1 = hi_i + ONE;
        ptr_p1 = ptr_i + ONE;
    end

    ofs_index_add #(.W(W)) i_index_add (
        .base_i  (lo_i),
        .index_i (idx),
        .sum_o   (sum),
        .carry_o (carry)
    );

    // Purpose: decode the bus cycle for the current step and mode.
    always_comb begin
        addr_o    = pc_i;
        pc_inc_o  = 1'b0;
        last_o    = 1'b0;
        step_nx_o = step_i;
        lo_nx_o   = lo_i;
        hi_nx_o   = hi_i;
        ptr_nx_o  = ptr_i;
        case (step_i)
            ST_C0: begin
                addr_o    = pc_i;
                pc_inc_o  = 1'b1;
                lo_nx_o   = rdata_i;
                last_o    = (mode_i == AM_IMM);
                step_nx_o = ST_C1;
            end
            ST_C1: begin
                step_nx_o = ST_C2;
                case (mode_i)
                    AM_ZP: begin
                        addr_o = {ZERO_PAGE, lo_i};
                        last_o = 1'b1;
                    end
                    AM_ZPX, AM_ZPY, AM_INDX: begin
                        addr_o  = {ZERO_PAGE, lo_i};
                        lo_nx_o = sum;
                    end
                    AM_ABS, AM_ABSX, AM_ABSY: begin
                        addr_o   = pc_i;
                        pc_inc_o = 1'b1;
                        hi_nx_o  = rdata_i;
                    end
                    AM_INDY: begin
                        addr_o   = {ZERO_PAGE, lo_i};
                        ptr_nx_o = lo_i;
                        lo_nx_o  = rdata_i;
                    end
                    default: last_o = 1'b1;
                endcase
            end
            ST_C2: begin
                step_nx_o = ST_C3;
                case (mode_i)
                    AM_ZPX, AM_ZPY: begin
                        addr_o = {ZERO_PAGE, lo_i};
                        last_o = 1'b1;
                    end
                    AM_ABS: begin
                        addr_o = {hi_i, lo_i};
                        last_o = 1'b1;
                    end
                    AM_ABSX, AM_ABSY: begin
                        addr_o  = {hi_i, sum};
                        lo_nx_o = sum;
                        last_o  = !carry;
                    end
                    AM_INDX: begin
                        addr_o   = {ZERO_PAGE, lo_i};
                        ptr_nx_o = lo_i;
                        lo_nx_o  = rdata_i;
                    end
                    AM_INDY: begin
                        addr_o  = {ZERO_PAGE, ptr_p1};
                        hi_nx_o = rdata_i;
                    end
                    default: last_o = 1'b1;
                endcase
            end
            ST_C3: begin
                step_nx_o = ST_C4;
                case (mode_i)
                    AM_ABSX, AM_ABSY: begin
                        addr_o = {hi_p1, lo_i};
                        last_o = 1'b1;
                    end
                    AM_INDX: begin
                        addr_o  = {ZERO_PAGE, ptr_p1};
                        hi_nx_o = rdata_i;
                    end
                    AM_INDY: begin
                        addr_o  = {hi_i, sum};
                        lo_nx_o = sum;
                        last_o  = !carry;
                    end
                    default: last_o = 1'b1;
                endcase
            end
            ST_C4: begin
                last_o = 1'b1;
                case (mode_i)
                    AM_INDX: addr_o = {hi_i, lo_i};
                    AM_INDY: addr_o = {hi_p1, lo_i};
                    default: addr_o = {hi_i, lo_i};
                endcase
            end
            default: begin
                addr_o = pc_i;
            end
        endcase
        if (last_o) begin
            step_nx_o = ST_IDLE;
        end
    end

endmodule

// File: rtl/operand_fetch_seq.sv
// Module: top of the operand fetch sequencer. It accepts a start with a
// mode code while idle, samples the index registers, steps through the
// mode's bus cycles and pulses done with the operand byte one cycle after
// the last read. Assumes a same-cycle memory read port and an external
// PC that increments at each edge where pc_inc_o is high.
module operand_fetch_seq
    import ofs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [DATA_W-1:0]   x_i,
    input  logic [DATA_W-1:0]   y_i,
    input  logic [2*DATA_W-1:0] pc_i,
    output logic                pc_inc_o,
    output logic [2*DATA_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [DATA_W-1:0]   operand_o
);

    localparam int ADDR_W = 2 * DATA_W;

    step_e              step_q;
    step_e              step_nx;
    amode_e             mode_q;
    logic [DATA_W-1:0]  lo_q, hi_q, ptr_q;
    logic [DATA_W-1:0]  lo_nx, hi_nx, ptr_nx;
    logic [DATA_W-1:0]  x_q, y_q;
    logic               last;
    logic               dec_inc;
    logic [ADDR_W-1:0]  dec_addr;
    logic               done_q;
    logic [DATA_W-1:0]  operand_q;
    logic               mode_ok;

    // Purpose: classify the requested mode code as usable.
    always_comb begin
        mode_ok = (mode_i <= MODE_W'(MODE_LAST));
        busy_o  = (step_q != ST_IDLE);
    end

    ofs_step_decode #(.W(DATA_W)) i_step_decode (
        .step_i    (step_q),
        .mode_i    (mode_q),
        .lo_i      (lo_q),
        .hi_i      (hi_q),
        .ptr_i     (ptr_q),
        .x_i       (x_q),
        .y_i       (y_q),
        .pc_i      (pc_i),
        .rdata_i   (mem_rdata_i),
        .addr_o    (dec_addr),
        .pc_inc_o  (dec_inc),
        .last_o    (last),
        .step_nx_o (step_nx),
        .lo_nx_o   (lo_nx),
        .hi_nx_o   (hi_nx),
        .ptr_nx_o  (ptr_nx)
    );

    // Purpose: start acceptance, step advance, working bytes and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= ST_IDLE;
            mode_q    <= AM_IMM;
            lo_q      <= '0;
            hi_q      <= '0;
            ptr_q     <= '0;
            x_q       <= '0;
            y_q       <= '0;
            done_q    <= 1'b0;
            operand_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (step_q == ST_IDLE) begin
                if (start_i && mode_ok) begin
                    step_q <= ST_C0;
                    mode_q <= amode_e'(mode_i);
                    x_q    <= x_i;
                    y_q    <= y_i;
                end
            end else begin
                step_q <= step_nx;
                lo_q   <= lo_nx;
                hi_q   <= hi_nx;
                ptr_q  <= ptr_nx;
                if (last) begin
                    done_q    <= 1'b1;
                    operand_q <= mem_rdata_i;
                end
            end
        end
    end

    // Purpose: drive the outputs from decode and result registers.
    always_comb begin
        pc_inc_o   = busy_o && dec_inc;
        mem_addr_o = dec_addr;
        done_o     = done_q;
        operand_o  = operand_q;
    end

endmodule

// File: rtl/operand_fetch_seq_chk.sv
// Module: assertion checker for operand_fetch_seq, attached by bind.
// Assumes the internal step and mode registers are brought out to it.
module operand_fetch_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [3:0]  mode_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        pc_inc_o,
    input logic [15:0] mem_addr_o,
    input logic [3:0]  mode_q,
    input logic [2:0]  step_q
);

    // R9
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    pc_inc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc_o |-> busy_o);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_q != 3'd1) |-> $stable(mode_q));

    // R11
    bad_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && mode_i > 4'd8) |=> !busy_o);

    // R4
    zp_index_page0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (mode_q == 4'd2 || mode_q == 4'd3) && step_q == 3'd3)
            |-> mem_addr_o[15:8] == 8'h00);

    // R7
    indx_ptr_page0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_q == 4'd7 && step_q >= 3'd2 && step_q <= 3'd4)
            |-> mem_addr_o[15:8] == 8'h00);

endmodule

bind operand_fetch_seq operand_fetch_seq_chk i_operand_fetch_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pc_inc_o   (pc_inc_o),
    .mem_addr_o (mem_addr_o),
    .mode_q     (mode_q),
    .step_q     (step_q)
);

// File: tb/test_operand_fetch_seq.sv
module test_operand_fetch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [7:0]  xr = 8'd0, yr = 8'd0;
    logic [15:0] pc;
    logic        pc_inc;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        busy, done;
    logic [7:0]  operand;

    int errors = 0;
    int checks = 0;

    logic [15:0] p_addr [8];
    logic [7:0]  p_data [8];
    int          p_n = 0;
    int          p_gen = 0;

    always #10 clk = ~clk;

    operand_fetch_seq i_operand_fetch_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .x_i(xr), .y_i(yr), .pc_i(pc), .pc_inc_o(pc_inc),
        .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .operand_o(operand)
    );

    // External program counter.
    always @(posedge clk) begin
        if (!rst_n) pc <= 16'h0200;
        else if (pc_inc) pc <= pc + 16'd1;
    end

    function automatic logic [7:0] mread(logic [15:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd29;
        t = t ^ (a[15:8] * 8'd7) ^ 8'hA5;
        for (int i = 0; i < 8; i++)
            if (i < p_n && p_addr[i] == a) t = p_data[i];
        return t;
    endfunction

    always @(mem_addr or p_gen) mem_rdata = mread(mem_addr);

    task automatic patch(logic [15:0] a, logic [7:0] d);
        p_addr[p_n] = a;
        p_data[p_n] = d;
        p_n++;
        p_gen++;
    endtask

    task automatic clear_patch();
        p_n = 0;
        p_gen++;
    endtask

    // Expected operand, busy-cycle count and PC advance from the requirements.
    function automatic void model(logic [3:0] m, logic [15:0] pc0, logic [7:0] xv,
                                  logic [7:0] yv, output logic [7:0] op,
                                  output int cyc, output int inc);
        logic [7:0]  lo, hi, p, idx;
        logic [15:0] ea;
        logic [8:0]  s;
        lo = mread(pc0);
        inc = 1;
        op = lo;
        cyc = 1;
        idx = (m == 4'd2 || m == 4'd5) ? xv : yv;
        case (m)
            4'd1: begin ea = {8'h00, lo}; cyc = 2; op = mread(ea); end
            4'd2, 4'd3: begin ea = {8'h00, lo + idx}; cyc = 3; op = mread(ea); end
            4'd4: begin hi = mread(pc0 + 16'd1); inc = 2; ea = {hi, lo}; cyc = 3; op = mread(ea); end
            4'd5, 4'd6: begin
                hi = mread(pc0 + 16'd1); inc = 2;
                s = {1'b0, lo} + {1'b0, idx};
                cyc = s[8] ? 4 : 3;
                ea = {hi, lo} + {8'h00, idx};
                op = mread(ea);
            end
            4'd7: begin
                p = lo + xv;
                ea = {mread({8'h00, p + 8'd1}), mread({8'h00, p})};
                cyc = 5; op = mread(ea);
            end
            4'd8: begin
                p = mread({8'h00, lo});
                s = {1'b0, p} + {1'b0, yv};
                ea = {mread({8'h00, lo + 8'd1}), p} + {8'h00, yv};
                cyc = s[8] ? 5 : 4; op = mread(ea);
            end
            default: ;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [3:0] m, logic [7:0] xv, logic [7:0] yv,
                          string req, bit disturb);
        logic [7:0]  eop;
        int          ecyc, einc, cyc;
        bit          seen;
        logic [15:0] pc0;
        pc0 = pc;
        model(m, pc0, xv, yv, eop, ecyc, einc);
        start = 1'b1; mode = m; xr = xv; yr = yv;
        @(negedge clk);
        cyc = 0; seen = 0;
        for (int k = 0; k < 12; k++) begin
            if (done) begin seen = 1; break; end
            if (busy) cyc++;
            if (disturb && k == 0) begin
                // R10 R12: start while busy and index changes
                start = 1'b1; mode = 4'd0; xr = ~xv; yr = ~yv;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(seen, {req, " done seen"}, seen, 1);
        check(operand == eop, {req, " operand"}, operand, eop);
        check(cyc == ecyc, {req, " busy cycles"}, cyc, ecyc);
        check(int'(pc - pc0) == einc, {req, " pc advance"}, int'(pc - pc0), einc);
        @(negedge clk);
        // R9: done lasts one cycle
        check(!done, "R9 done single", done, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] pc0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !pc_inc, "R1 in reset", {busy, done, pc_inc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !pc_inc, "R1 after reset", {busy, done, pc_inc}, 0);

        // R2 immediate
        clear_patch(); patch(pc, 8'h3C);
        run_op(4'd0, 8'h00, 8'h00, "R2 immediate", 0);
        // R3 zero page
        clear_patch(); patch(pc, 8'h40); patch(16'h0040, 8'h77);
        run_op(4'd1, 8'h00, 8'h00, "R3 zero page", 0);
        // R4 zero page X wraps in page 0
        clear_patch(); patch(pc, 8'hF0); patch(16'h0010, 8'h5E);
        run_op(4'd2, 8'h20, 8'h00, "R4 zpx wrap", 0);
        clear_patch(); patch(pc, 8'h10);
        run_op(4'd3, 8'h00, 8'h05, "R4 zpy", 0);
        // R5 absolute
        clear_patch(); patch(pc, 8'h34); patch(pc + 16'd1, 8'h12); patch(16'h1234, 8'hC3);
        run_op(4'd4, 8'h00, 8'h00, "R5 absolute", 0);
        // R6 sum exactly 255: no crossing
        clear_patch(); patch(pc, 8'h80); patch(pc + 16'd1, 8'h30);
        run_op(4'd5, 8'h7F, 8'h00, "R6 absx no cross", 0);
        // R6 crossing
        clear_patch(); patch(pc, 8'h80); patch(pc + 16'd1, 8'h30); patch(16'h3100, 8'hE1);
        run_op(4'd6, 8'h00, 8'h80, "R6 absy cross", 0);
        // R7 pointer at 0xFF wraps to 0x00
        clear_patch(); patch(pc, 8'hFE); patch(16'h00FF, 8'h22); patch(16'h0000, 8'h41);
        patch(16'h4122, 8'h99);
        run_op(4'd7, 8'h01, 8'h00, "R7 indx wrap", 0);
        // R8 pointer at 0xFF, crossing and not
        clear_patch(); patch(pc, 8'hFF); patch(16'h00FF, 8'hF0); patch(16'h0000, 8'h12);
        run_op(4'd8, 8'h00, 8'h20, "R8 indy cross", 0);
        clear_patch(); patch(pc, 8'hFF); patch(16'h00FF, 8'hF0); patch(16'h0000, 8'h12);
        run_op(4'd8, 8'h00, 8'h0F, "R8 indy no cross", 0);

        // R11: invalid mode codes ignored
        for (int c = 9; c < 16; c += 6) begin
            pc0 = pc;
            start = 1'b1; mode = 4'(c);
            @(negedge clk);
            start = 1'b0;
            check(!busy && !pc_inc, "R11 bad mode idle", {busy, pc_inc}, 0);
            @(negedge clk);
            check(!busy && pc == pc0, "R11 bad mode pc", pc, pc0);
        end

        // R10 R12: start and index changes during a running fetch
        clear_patch(); patch(pc, 8'hF0); patch(pc + 16'd1, 8'h44);
        run_op(4'd5, 8'h20, 8'h00, "R10 R12 absx disturb", 1);
        clear_patch();
        run_op(4'd8, 8'h00, 8'hC7, "R10 R12 indy disturb", 1);

        // Random mix over all modes
        for (int n = 0; n < 150; n++) begin
            logic [3:0] m;
            m = 4'($urandom_range(0, 8));
            clear_patch();
            patch(pc, 8'($urandom));
            patch(pc + 16'd1, 8'($urandom));
            run_op(m, 8'($urandom), 8'($urandom), "R2-mix random", n % 7 == 3);
        end
        finish_run();
    end

endmodule